// File: doc/BRIEF.md
# Eight-Pin I/O Port with Strobe and Clock Pin Overrides

This block is one eight-pin general-purpose I/O port. Software sets it up through a small register bus. The bus reaches two registers: an output-value register and a pin-direction register. On each pin, the block decides whether the pad is driven and what value goes out. On reads, it returns either the stored output value or the pin level as seen by a two-flop synchronizer, depending on the pin's direction. Two pins carry fixed alternate roles. Pin 6 drives a system clock level when it is set as an output, and software can never write its data bit. Pin 0 is taken over by the low-byte write strobe when the chip runs in expanded-bus mode with the narrow-bus setting.

A three-state power controller sits beside the registers. Its states are `PWR_RUN`, `PWR_SOFT` (software standby) and `PWR_HARD` (hardware standby).
- A hardware standby request moves any state to `PWR_HARD`.
- A software standby request without a hardware request moves `PWR_RUN` or `PWR_HARD` to `PWR_SOFT`.
- When neither request is present, `PWR_SOFT` and `PWR_HARD` return to `PWR_RUN`.

Register writes are accepted only while the controller is in `PWR_RUN` and neither request is raised. Every clock edge with a hardware request clears both registers. Software standby keeps both registers unchanged.

Top module: `pinmux_gpio_port`

## Requirements
- R1: After reset both registers are 0x00, every output enable is low, and a read at address 0 returns 0x00 until pin levels pass the synchronizer.
- R2: A write is applied at the next clock edge. Address 0 selects the output-value register and address 1 selects the direction register (bit set = output). A read at address 1 always returns 0x00.
- R3: A read at address 0 returns, for each bit, the stored output value when the direction bit is 1. When the direction bit is 0, it returns the synchronized pin level. A pin level present before clock edge k appears in read data after edge k+1.
- R4: Bit 6 of the output-value register cannot be written. Its read bit is always the synchronized level of pin 6, whatever the direction.
- R5: At every clock edge where the hardware standby request is high, both registers clear to 0x00 and any write is ignored.
- R6: While the software standby request is high, or the controller has not yet returned to `PWR_RUN`, writes are ignored and both registers keep their contents.
- R7: With expanded mode high and the bus-width input low, pin 0 is driven (enable 1) with the strobe input, whatever its direction bit. The mode and bus-width inputs act without a clock delay.
- R8: With expanded mode low, or the bus-width input high, pin 0 behaves as an ordinary pin.
- R9: Pin 6 with its direction bit set is driven with the system clock input.
- R10: Any other pin is driven with its output-value bit when its direction bit is 1. Apart from the pin 0 override, a pin with direction bit 0 has enable 0 and output value 0.
- R11: When the read enable is low, read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 1 | Register select: 0 output value, 1 direction |
| bus_wr_i | input | 1 | Write enable |
| bus_rd_i | input | 1 | Read enable |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| exp_mode_i | input | 1 | 1 = expanded-bus mode, 0 = single-chip mode |
| bus_wide_i | input | 1 | Bus-width setting; 0 selects the pin 0 strobe override in expanded mode |
| lo_strobe_i | input | 1 | Low-byte write strobe level |
| sys_clk_i | input | 1 | System clock level for pin 6 |
| sw_stby_i | input | 1 | Software standby request |
| hw_stby_i | input | 1 | Hardware standby request |

## Verification
Two kinds of events can land in the same cycle.
- A register write can coincide with a standby request. The bench issues writes in the cycle a software or hardware request rises, and again in the cycle after it falls. The controller is still leaving its standby state in that later cycle, so the write must be dropped there too.
- A direction change on pin 0 or pin 6 can coincide with the override that owns that pin. The bench toggles the direction of pin 0 under the strobe override, and flips the mode and bus-width inputs between cycles.

The reference model in the bench judges every cycle. It checks enables, output values and read data against the state it computes on its own.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_SOFT = 2'd1,
        PWR_HARD = 2'd2
    } pwr_state_e;

    localparam int unsigned REG_OUT = 0;
    localparam int unsigned REG_DIR = 1;
endpackage

// File: rtl/gpio_pinmux_pwr.sv
module gpio_pinmux_pwr
    import gpio_pinmux_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_stby_i,
    input  logic hw_stby_i,
    output logic wr_allow_o,
    output logic clr_o
);
    pwr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= PWR_RUN;
        else         state_q <= state_d;
    end

    // transitions: hardware request wins, then software request, else run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_RUN: begin
                if (hw_stby_i)      state_d = PWR_HARD;
                else if (sw_stby_i) state_d = PWR_SOFT;
            end
            PWR_SOFT: begin
                if (hw_stby_i)       state_d = PWR_HARD;
                else if (!sw_stby_i) state_d = PWR_RUN;
            end
            PWR_HARD: begin
                if (!hw_stby_i) state_d = sw_stby_i ? PWR_SOFT : PWR_RUN;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    // outputs
    always_comb begin
        wr_allow_o = 1'b0;
        clr_o      = hw_stby_i;
        unique case (state_q)
            PWR_RUN:  wr_allow_o = !sw_stby_i && !hw_stby_i;
            PWR_SOFT: wr_allow_o = 1'b0;
            PWR_HARD: wr_allow_o = 1'b0;
            default:  wr_allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
    import gpio_pinmux_pkg::*;
#(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned RO_PIN = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              wr_allow_i,
    input  logic              clr_i,
    output logic [WIDTH-1:0]  out_q_o,
    output logic [WIDTH-1:0]  dir_q_o
);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(REG_OUT);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(REG_DIR);

    logic wr_out, wr_dir;
    assign wr_out = wr_i && wr_allow_i && (addr_i == A_OUT);
    assign wr_dir = wr_i && wr_allow_i && (addr_i == A_DIR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     dir_q_o <= '0;
        else if (clr_i)  dir_q_o <= '0;
        else if (wr_dir) dir_q_o <= wdata_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_out
        if (i == RO_PIN) begin : g_ro
            assign out_q_o[i] = 1'b0;
        end else begin : g_rw
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)     out_q_o[i] <= 1'b0;
                else if (clr_i)  out_q_o[i] <= 1'b0;
                else if (wr_out) out_q_o[i] <= wdata_i[i];
            end
        end
    end
endmodule

// File: rtl/gpio_pinmux_sync.sv
module gpio_pinmux_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pinmux_mux.sv
module gpio_pinmux_mux
    import gpio_pinmux_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned ADDR_W     = 1,
    parameter int unsigned CLK_PIN    = 6,
    parameter int unsigned STROBE_PIN = 0
) (
    input  logic [WIDTH-1:0]  out_q_i,
    input  logic [WIDTH-1:0]  dir_q_i,
    input  logic [WIDTH-1:0]  sync_i,
    input  logic              exp_mode_i,
    input  logic              bus_wide_i,
    input  logic              lo_strobe_i,
    input  logic              sys_clk_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WIDTH-1:0]  pin_oe_o,
    output logic [WIDTH-1:0]  pin_out_o,
    output logic [WIDTH-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(REG_OUT);

    logic strobe_take;
    logic [WIDTH-1:0] rd_bits;
    assign strobe_take = exp_mode_i && !bus_wide_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i == CLK_PIN) begin : g_clk
            assign pin_oe_o[i]  = dir_q_i[i];
            assign pin_out_o[i] = dir_q_i[i] & sys_clk_i;
            assign rd_bits[i]   = sync_i[i];
        end else if (i == STROBE_PIN) begin : g_stb
            assign pin_oe_o[i]  = strobe_take | dir_q_i[i];
            assign pin_out_o[i] = strobe_take ? lo_strobe_i : (dir_q_i[i] & out_q_i[i]);
            assign rd_bits[i]   = dir_q_i[i] ? out_q_i[i] : sync_i[i];
        end else begin : g_gen
            assign pin_oe_o[i]  = dir_q_i[i];
            assign pin_out_o[i] = dir_q_i[i] & out_q_i[i];
            assign rd_bits[i]   = dir_q_i[i] ? out_q_i[i] : sync_i[i];
        end
    end

    assign rdata_o = (rd_i && addr_i == A_OUT) ? rd_bits : '0;
endmodule

// File: rtl/pinmux_gpio_port.sv
module pinmux_gpio_port
    import gpio_pinmux_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ADDR_W      = 1,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLK_PIN     = 6,
    parameter int unsigned STROBE_PIN  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  pin_in_i,
    output logic [WIDTH-1:0]  pin_out_o,
    output logic [WIDTH-1:0]  pin_oe_o,
    input  logic              exp_mode_i,
    input  logic              bus_wide_i,
    input  logic              lo_strobe_i,
    input  logic              sys_clk_i,
    input  logic              sw_stby_i,
    input  logic              hw_stby_i
);
    logic             wr_allow, clr;
    logic [WIDTH-1:0] out_q, dir_q, pin_sync;

    gpio_pinmux_pwr u_pwr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sw_stby_i  (sw_stby_i),
        .hw_stby_i  (hw_stby_i),
        .wr_allow_o (wr_allow),
        .clr_o      (clr)
    );

    gpio_pinmux_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .RO_PIN(CLK_PIN)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .wr_allow_i (wr_allow),
        .clr_i      (clr),
        .out_q_o    (out_q),
        .dir_q_o    (dir_q)
    );

    gpio_pinmux_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_in_i),
        .q_o    (pin_sync)
    );

    gpio_pinmux_mux #(
        .WIDTH(WIDTH), .ADDR_W(ADDR_W), .CLK_PIN(CLK_PIN), .STROBE_PIN(STROBE_PIN)
    ) u_mux (
        .out_q_i     (out_q),
        .dir_q_i     (dir_q),
        .sync_i      (pin_sync),
        .exp_mode_i  (exp_mode_i),
        .bus_wide_i  (bus_wide_i),
        .lo_strobe_i (lo_strobe_i),
        .sys_clk_i   (sys_clk_i),
        .rd_i        (bus_rd_i),
        .addr_i      (bus_addr_i),
        .pin_oe_o    (pin_oe_o),
        .pin_out_o   (pin_out_o),
        .rdata_o     (bus_rdata_o)
    );
endmodule

// File: rtl/pinmux_gpio_port_chk.sv
module pinmux_gpio_port_chk #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned ADDR_W     = 1,
    parameter int unsigned CLK_PIN    = 6,
    parameter int unsigned STROBE_PIN = 0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rd_i,
    input logic [WIDTH-1:0]  bus_rdata_o,
    input logic [WIDTH-1:0]  pin_out_o,
    input logic [WIDTH-1:0]  pin_oe_o,
    input logic              exp_mode_i,
    input logic              bus_wide_i,
    input logic              lo_strobe_i,
    input logic              sys_clk_i,
    input logic              sw_stby_i,
    input logic              hw_stby_i,
    input logic [WIDTH-1:0]  out_q,
    input logic [WIDTH-1:0]  dir_q
);
    a_r7_strobe_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exp_mode_i && !bus_wide_i) |-> (pin_oe_o[STROBE_PIN] && pin_out_o[STROBE_PIN] == lo_strobe_i));

    a_r9_clock_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_oe_o[CLK_PIN] |-> (pin_out_o[CLK_PIN] == sys_clk_i));

    a_r5_hard_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_stby_i |=> (out_q == '0 && dir_q == '0 && pin_oe_o[CLK_PIN] == 1'b0));

    a_r6_soft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_stby_i && !hw_stby_i) |=> ($stable(out_q) && $stable(dir_q)));

    a_r11_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_rd_i |-> (bus_rdata_o == '0));

    a_r2_dir_unreadable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == ADDR_W'(1)) |-> (bus_rdata_o == '0));

    a_r10_oe_needs_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(exp_mode_i && !bus_wide_i) |-> ((pin_oe_o & ~dir_q) == '0));
endmodule

bind pinmux_gpio_port pinmux_gpio_port_chk #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .CLK_PIN(CLK_PIN), .STROBE_PIN(STROBE_PIN)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .exp_mode_i  (exp_mode_i),
    .bus_wide_i  (bus_wide_i),
    .lo_strobe_i (lo_strobe_i),
    .sys_clk_i   (sys_clk_i),
    .sw_stby_i   (sw_stby_i),
    .hw_stby_i   (hw_stby_i),
    .out_q       (out_q),
    .dir_q       (dir_q)
);

// File: tb/pinmux_gpio_port_test.sv
module pinmux_gpio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, pout, poe;
    logic [7:0] pin = '0;
    logic       expm = 1'b0, wide = 1'b0, stb = 1'b0, sclk = 1'b0;
    logic       sw = 1'b0, hw = 1'b0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    pinmux_gpio_port uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pin), .pin_out_o(pout),
        .pin_oe_o(poe), .exp_mode_i(expm), .bus_wide_i(wide), .lo_strobe_i(stb),
        .sys_clk_i(sclk), .sw_stby_i(sw), .hw_stby_i(hw)
    );

    // behavioural reference model
    logic [7:0] m_out, m_dir;
    logic [7:0] hist[$];
    int m_st;  // 0 run, 1 software standby, 2 hardware standby

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 8'h00; m_dir = 8'h00; hist.delete(); m_st = 0;
        end else begin
            hist.push_front(pin);
            if (hist.size() > 2) void'(hist.pop_back());
            if (hw) begin
                m_out = 8'h00; m_dir = 8'h00;
            end else if (m_st == 0 && !sw && wr) begin
                if (addr == 1'b0) m_out = wdata & 8'hBF;
                else              m_dir = wdata;
            end
            m_st = hw ? 2 : (sw ? 1 : 0);
        end
    end

    task automatic check(string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got=%h expected=%h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] syn, e_oe, e_out, e_rd;
        syn = (hist.size() == 2) ? hist[1] : 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (i == 0 && expm && !wide) begin
                e_oe[i] = 1'b1; e_out[i] = stb;
            end else if (m_dir[i]) begin
                e_oe[i] = 1'b1; e_out[i] = (i == 6) ? sclk : m_out[i];
            end else begin
                e_oe[i] = 1'b0; e_out[i] = 1'b0;
            end
            e_rd[i] = (i == 6) ? syn[i] : (m_dir[i] ? m_out[i] : syn[i]);
        end
        if (!(rd && addr == 1'b0)) e_rd = 8'h00;
        check("pin_oe", poe, e_oe);
        check("pin_out", pout, e_out);
        check("rdata", rdata, e_rd);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; addr = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        rd = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("reset oe", poe, 8'h00);

        // R2: writes to both registers, direction register reads as zero
        cur_req = "R2";
        bus_write(1'b1, 8'hFF);
        bus_write(1'b0, 8'hFF);
        tick();
        addr = 1'b1; tick(); addr = 1'b0;

        // R4: bit 6 not writable, reads pin 6
        cur_req = "R4";
        pin = 8'h40; repeat (3) tick();
        pin = 8'h00; repeat (3) tick();

        // R3: mixed directions, synchronizer latency
        cur_req = "R3";
        bus_write(1'b1, 8'h0F);
        bus_write(1'b0, 8'h5A);
        pin = 8'h3C; tick(); tick(); tick();
        pin = 8'hC3; tick(); tick(); tick();
        pin = 8'hA5; repeat (3) tick();

        // R10: output patterns
        cur_req = "R10";
        bus_write(1'b1, 8'hBF);
        bus_write(1'b0, 8'h81);
        bus_write(1'b0, 8'h3E);
        bus_write(1'b1, 8'h00); tick();

        // R9: clock pin
        cur_req = "R9";
        bus_write(1'b1, 8'h40);
        for (int k = 0; k < 4; k++) begin sclk = ~sclk; tick(); end
        expm = 1'b1; wide = 1'b1; sclk = 1'b1; tick(); sclk = 1'b0; tick();
        expm = 1'b0;

        // R7: strobe override, direction toggled under it
        cur_req = "R7";
        bus_write(1'b1, 8'h00);
        expm = 1'b1; wide = 1'b0;
        for (int k = 0; k < 4; k++) begin stb = ~stb; tick(); end
        bus_write(1'b1, 8'h01); stb = 1'b1; tick(); stb = 1'b0; tick();
        bus_write(1'b0, 8'h01);
        bus_write(1'b1, 8'h00); tick();

        // R8: ordinary pin 0
        cur_req = "R8";
        wide = 1'b1; stb = 1'b1; tick();
        bus_write(1'b1, 8'h01); tick();
        expm = 1'b0; wide = 1'b0; tick();
        bus_write(1'b0, 8'h00); tick();
        stb = 1'b0;

        // R6: software standby holds, writes dropped incl. exit cycle
        cur_req = "R6";
        bus_write(1'b1, 8'hF0);
        bus_write(1'b0, 8'h90);
        sw = 1'b1;
        bus_write(1'b0, 8'h0F);
        bus_write(1'b1, 8'h0F);
        tick();
        sw = 1'b0;
        bus_write(1'b0, 8'h22);
        tick();
        bus_write(1'b0, 8'h33); tick();

        // R5: hardware standby clears, writes dropped
        cur_req = "R5";
        bus_write(1'b1, 8'hFF);
        hw = 1'b1;
        bus_write(1'b0, 8'hFF);
        bus_write(1'b1, 8'hFF);
        tick();
        hw = 1'b0;
        bus_write(1'b1, 8'hFF);
        tick();
        bus_write(1'b1, 8'hFF); tick();
        sw = 1'b1; hw = 1'b1; tick(); hw = 1'b0; tick(); sw = 1'b0; tick(); tick();

        // R11: idle read returns zero
        cur_req = "R11";
        bus_write(1'b0, 8'hFF);
        rd = 1'b0; tick(); tick();
        check("idle rdata", rdata, 8'h00);
        rd = 1'b1; tick();

        summary();
        $finish;
    end
endmodule